// File: doc/BRIEF.md
# Converter Control Register with Offset Correction

This block models the write-only 12-bit control word of a two-input sampling converter, together with the output path that the word controls. A host loads the word over a parallel bus. The bus strobes can be read in two ways. In split mode there is one read line and one write line. In joint mode the write line acts as a single direction line: high means read and low means write, and the read line is ignored. A chip select qualifies every access in both modes. A write is accepted only when the top two bits of the word carry the register's address code.

The word sets five things: a held soft reset, a one-shot pulse to the sync generator, the bus strobe mode, the output coding and a start command for offset calibration. On a calibration start the block asks the front end for one conversion with its inputs forced to zero, and stores the result as the offset. Each later 10-bit sample has the offset subtracted, is clamped to the signed 10-bit range, and is emitted in twos complement or in offset binary. A host read returns the most recently emitted sample.

Top module: `adc_ctrl_offset`

## Requirements
- R1: After the synchronous reset `rst`, the outputs `out_valid`, `out_data`, `rd_valid`, `rd_data`, `cal_busy`, `zero_req` and `sync_rst` are all 0. Split strobe mode and twos complement coding are selected, and the stored offset is 0.
- R2: A write is accepted only when `bus_wdata[11]`=1 and `bus_wdata[10]`=0. Any other code in those two bits leaves every field unchanged. Each accepted write loads all fields from the word.
- R3: In split mode (word bit 6 = 0), `bus_sel`&`bus_wr` is a write. `bus_sel`&`bus_rd` is a read, which raises `rd_valid` for one cycle one clock later, with `rd_data` equal to the last emitted `out_data`.
- R4: In joint mode (word bit 6 = 1), `bus_sel` with `bus_wr`=0 is a write and `bus_sel` with `bus_wr`=1 is a read. `bus_rd` has no effect in this mode.
- R5: Word bit 7 = 0 gives twos complement output. Bit 7 = 1 gives offset binary output, formed by inverting the MSB of the twos complement result.
- R6: When `raw_valid` is high outside calibration and soft reset, `out_valid` is high one clock later. `out_data` then holds `raw_data` minus the stored offset, both taken as signed 10-bit values.
- R7: An accepted write with bit 8 = 1 (and bit 0 = 0) raises `cal_busy` and a one-cycle `zero_req` one clock later. The next `raw_valid` sample becomes the stored offset and produces no output, and `cal_busy` falls one clock after that sample.
- R8: The subtraction saturates at +511 and at -512 instead of wrapping.
- R9: An accepted write with bit 0 = 1 enters soft reset. Fields return to reset values (split mode, twos complement), the offset and the last emitted value clear to 0, and calibration is abandoned. Samples produce no output until a write with bit 0 = 0.
- R10: An accepted write with bit 1 = 1 (and bit 0 = 0) drives `sync_rst` high for exactly one cycle, one clock after the write.
- R11: Before any calibration, samples pass through with no change apart from the output coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Chip select that qualifies a bus access |
| bus_rd | input | 1 | Read strobe (split mode only) |
| bus_wr | input | 1 | Write strobe in split mode, direction line in joint mode |
| bus_wdata | input | 12 | Control word |
| raw_valid | input | 1 | Raw sample valid |
| raw_data | input | 10 | Raw sample, signed |
| zero_req | output | 1 | One-cycle request for a zero-input conversion |
| cal_busy | output | 1 | Calibration in progress |
| sync_rst | output | 1 | One-cycle sync generator reset |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 10 | Corrected, coded sample |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 10 | Last emitted sample |

## Verification
Every result of this block is due exactly one clock after its cause. The corrected sample follows `raw_valid`, `rd_valid` follows the read strobe, and `sync_rst`, `cal_busy` and `zero_req` follow the accepting write. The bench drives each stimulus at a falling edge and holds it across one rising edge. It then samples at the next falling edge, where that single register stage has just updated. For the checks of single-cycle width, it samples again one falling edge later. Any output that a stimulus must not produce, such as a sample swallowed by calibration or soft reset, is checked at that same falling edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int CTL_W    = 12;
  localparam int F_SRST   = 0;
  localparam int F_SYNC   = 1;
  localparam int F_JOINT  = 6;
  localparam int F_BIN    = 7;
  localparam int F_CAL    = 8;
  localparam int A_HI     = 11;
  localparam int A_LO     = 10;
  localparam logic [1:0] A_CODE = 2'b10;

  typedef struct packed {
    logic held_rst;
    logic joint;
    logic bin;
  } ctl_t;

  localparam ctl_t CTL_RST = '{held_rst: 1'b0, joint: 1'b0, bin: 1'b0};
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode (
  input  logic joint,
  input  logic sel,
  input  logic rd,
  input  logic wr,
  output logic wr_en,
  output logic rd_en
);
  always_comb begin
    if (joint) begin
      wr_en = sel & ~wr;
      rd_en = sel & wr;
    end else begin
      wr_en = sel & wr;
      rd_en = sel & rd;
    end
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic             sync_rst,
  output logic             cal_start,
  output logic             soft_clr
);
  logic acc;

  assign acc       = wr_en && (wdata[A_HI:A_LO] == A_CODE);
  assign soft_clr  = acc && wdata[F_SRST];
  assign cal_start = acc && !wdata[F_SRST] && wdata[F_CAL];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= CTL_RST;
      sync_rst <= 1'b0;
    end else begin
      sync_rst <= 1'b0;
      if (acc) begin
        if (wdata[F_SRST]) begin
          ctl          <= CTL_RST;
          ctl.held_rst <= 1'b1;
        end else begin
          ctl.held_rst <= 1'b0;
          ctl.joint    <= wdata[F_JOINT];
          ctl.bin      <= wdata[F_BIN];
          sync_rst     <= wdata[F_SYNC];
        end
      end
    end
  end

  // R10
  sync_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    sync_rst |=> !sync_rst);
  // R9
  soft_enter_chk: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (ctl.held_rst && !ctl.joint && !ctl.bin));
  // R9
  soft_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !wdata[F_SRST]) |=> !ctl.held_rst);
endmodule

// File: rtl/adc_offset_path.sv
module adc_offset_path #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          cal_start,
  input  logic          held_rst,
  input  logic          bin,
  input  logic          raw_valid,
  input  logic [SW-1:0] raw_data,
  input  logic          rd_en,
  output logic          cal_busy,
  output logic          zero_req,
  output logic          out_valid,
  output logic [SW-1:0] out_data,
  output logic          rd_valid,
  output logic [SW-1:0] rd_data
);
  localparam logic signed [SW:0] MAXV = {2'b00, {(SW-1){1'b1}}};
  localparam logic signed [SW:0] MINV = {2'b11, {(SW-1){1'b0}}};
  localparam logic [SW-1:0]      MSB  = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0]     off_q;
  logic [SW-1:0]     last_q;
  logic signed [SW:0] diff;
  logic [SW-1:0]     clamped;
  logic [SW-1:0]     coded;

  always_comb begin
    diff = $signed({raw_data[SW-1], raw_data}) - $signed({off_q[SW-1], off_q});
    if (diff > MAXV)      clamped = MAXV[SW-1:0];
    else if (diff < MINV) clamped = MINV[SW-1:0];
    else                  clamped = diff[SW-1:0];
    coded = bin ? (clamped ^ MSB) : clamped;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      off_q     <= '0;
      last_q    <= '0;
      cal_busy  <= 1'b0;
      zero_req  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      zero_req  <= 1'b0;
      out_valid <= 1'b0;
      rd_valid  <= rd_en;
      rd_data   <= last_q;
      if (cal_start) begin
        cal_busy <= 1'b1;
        zero_req <= 1'b1;
      end else if (raw_valid && !held_rst) begin
        if (cal_busy) begin
          off_q    <= raw_data;
          cal_busy <= 1'b0;
        end else begin
          out_valid <= 1'b1;
          out_data  <= coded;
          last_q    <= coded;
        end
      end
    end
  end

  // R7
  zreq_busy_chk: assert property (@(posedge clk) disable iff (rst)
    zero_req |-> cal_busy);
  // R7
  zreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    zero_req |=> !zero_req);
  // R7
  cal_swallow_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && raw_valid && !held_rst && !cal_start && !soft_clr) |=> (!out_valid && !cal_busy));
  // R9
  held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (held_rst && raw_valid) |=> !out_valid);
  // R6
  sample_out_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_valid && !cal_busy && !held_rst && !cal_start && !soft_clr) |=> out_valid);
  // R3
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !soft_clr) |=> rd_valid);
endmodule

// File: rtl/adc_ctrl_offset.sv
module adc_ctrl_offset
  import adc_ctrl_pkg::*;
#(
  parameter int SW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [CTL_W-1:0] bus_wdata,
  input  logic             raw_valid,
  input  logic [SW-1:0]    raw_data,
  output logic             zero_req,
  output logic             cal_busy,
  output logic             sync_rst,
  output logic             out_valid,
  output logic [SW-1:0]    out_data,
  output logic             rd_valid,
  output logic [SW-1:0]    rd_data
);
  ctl_t ctl;
  logic wr_en, rd_en, cal_start, soft_clr;

  adc_bus_decode u_dec (
    .joint (ctl.joint),
    .sel   (bus_sel),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .wr_en (wr_en),
    .rd_en (rd_en)
  );

  adc_ctrl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wdata     (bus_wdata),
    .ctl       (ctl),
    .sync_rst  (sync_rst),
    .cal_start (cal_start),
    .soft_clr  (soft_clr)
  );

  adc_offset_path #(.SW(SW)) u_path (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .cal_start (cal_start),
    .held_rst  (ctl.held_rst),
    .bin       (ctl.bin),
    .raw_valid (raw_valid),
    .raw_data  (raw_data),
    .rd_en     (rd_en),
    .cal_busy  (cal_busy),
    .zero_req  (zero_req),
    .out_valid (out_valid),
    .out_data  (out_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
  // R4
  joint_rd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.joint && !bus_sel) |-> !(wr_en || rd_en));
endmodule

// File: tb/adc_ctrl_offset_tb.sv
module adc_ctrl_offset_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_wdata = '0;
  logic raw_valid = 1'b0;
  logic [9:0] raw_data = '0;
  logic zero_req, cal_busy, sync_rst, out_valid, rd_valid;
  logic [9:0] out_data, rd_data;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctrl_offset dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .raw_valid(raw_valid), .raw_data(raw_data),
    .zero_req(zero_req), .cal_busy(cal_busy), .sync_rst(sync_rst),
    .out_valid(out_valid), .out_data(out_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expv(int raw, int off, bit bin);
    int d = raw - off;
    if (d > 511) d = 511;
    if (d < -512) d = -512;
    d = d & 'h3FF;
    if (bin) d = d ^ 'h200;
    return d;
  endfunction

  task automatic bus_write(logic [11:0] d, bit joint);
    bus_sel = 1'b1; bus_rd = 1'b0; bus_wr = joint ? 1'b0 : 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(bit joint);
    bus_sel = 1'b1; bus_rd = joint ? 1'b0 : 1'b1; bus_wr = joint ? 1'b1 : 1'b0;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic sample(int v);
    raw_valid = 1'b1; raw_data = 10'(v);
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_data", out_data, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 cal_busy", cal_busy, 0);
    chk("R1 zero_req", zero_req, 0);
    chk("R1 sync_rst", sync_rst, 0);
  endtask

  task automatic t_pass;
    int vals[4] = '{0, 123, -77, 511};
    foreach (vals[i]) begin
      sample(vals[i]);
      chk("R6 valid", out_valid, 1);
      chk("R11 pass", out_data, expv(vals[i], 0, 0));
    end
    @(negedge clk);
    chk("R6 valid drop", out_valid, 0);
  endtask

  task automatic t_format;
    bus_write(12'h880, 0);
    sample(-3);
    chk("R5 bin neg", out_data, expv(-3, 0, 1));
    sample(0);
    chk("R5 bin zero", out_data, 'h200);
    bus_write(12'h800, 0);
    sample(-3);
    chk("R5 twos neg", out_data, 'h3FD);
  endtask

  task automatic t_prefix;
    bus_write(12'h480, 0);
    sample(-3);
    chk("R2 code 01 ignored", out_data, expv(-3, 0, 0));
    bus_write(12'hC80, 0);
    sample(-3);
    chk("R2 code 11 ignored", out_data, expv(-3, 0, 0));
    bus_write(12'h080, 0);
    sample(-3);
    chk("R2 code 00 ignored", out_data, expv(-3, 0, 0));
  endtask

  task automatic t_sep_read;
    sample(200);
    bus_read(0);
    chk("R3 rd_valid", rd_valid, 1);
    chk("R3 rd_data", rd_data, expv(200, 0, 0));
    @(negedge clk);
    chk("R3 rd_valid single", rd_valid, 0);
    bus_sel = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R3 no select no read", rd_valid, 0);
  endtask

  task automatic t_joint;
    bus_write(12'h840, 0);
    sample(-100);
    bus_read(1);
    chk("R4 joint read", rd_valid, 1);
    chk("R4 joint read data", rd_data, expv(-100, 0, 0));
    bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_wdata = 12'h8C0;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    chk("R4 rd ignored no read", rd_valid, 0);
    sample(-100);
    chk("R4 rd ignored write taken", out_data, expv(-100, 0, 1));
    bus_write(12'h800, 1);
    sample(-100);
    chk("R4 back to split", out_data, expv(-100, 0, 0));
  endtask

  task automatic t_sync;
    bus_write(12'h802, 0);
    chk("R10 sync high", sync_rst, 1);
    @(negedge clk);
    chk("R10 sync one cycle", sync_rst, 0);
    bus_write(12'h800, 0);
    chk("R10 no sync", sync_rst, 0);
  endtask

  task automatic t_cal(int off);
    bus_write(12'h900, 0);
    chk("R7 busy", cal_busy, 1);
    chk("R7 zero_req", zero_req, 1);
    @(negedge clk);
    chk("R7 zero_req one cycle", zero_req, 0);
    chk("R7 busy held", cal_busy, 1);
    sample(off);
    chk("R7 cal sample swallowed", out_valid, 0);
    chk("R7 busy clears", cal_busy, 0);
    sample(100);
    chk("R7 offset applied", out_data, expv(100, off, 0));
  endtask

  task automatic t_sat;
    t_cal(5);
    sample(-510);
    chk("R8 low clamp", out_data, 'h200);
    t_cal(-8);
    sample(508);
    chk("R8 high clamp", out_data, 'h1FF);
    sample(-515 + 8 + 5);
    chk("R8 near low", out_data, expv(-502, -8, 0));
  endtask

  task automatic t_soft;
    t_cal(7);
    bus_write(12'h840, 0);
    bus_write(12'h801, 1);
    sample(50);
    chk("R9 held no output", out_valid, 0);
    bus_read(0);
    chk("R9 split mode in reset", rd_valid, 1);
    chk("R9 last cleared", rd_data, 0);
    bus_write(12'h800, 0);
    sample(50);
    chk("R9 offset cleared", out_data, expv(50, 0, 0));
    chk("R9 output resumes", out_valid, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass();
    t_format();
    t_prefix();
    t_sep_read();
    t_joint();
    t_sync();
    t_cal(20);
    t_sat();
    t_soft();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule